// File: doc/BRIEF.md
# Masked Peripheral Register Bank

This block holds the byte-wide control and status registers that a small handheld-style system maps into its I/O space. A processor-side port provides an 8-bit address, write data with a write strobe, and a read strobe that returns 8-bit data. Each implemented address has its own storage byte. Each also has a fixed constant whose set bits mark bits with no storage behind them, and those bits always read as 1. Addresses with no register behind them read as 0xFF.

Writes follow per-register rules. The interrupt-flag byte always keeps its three top bits set. A write to the divider address stores nothing and emits a one-cycle reset pulse for the external timer. The sound registers depend on the sound engine's master-enable input. While that input is low, writes to sound registers store zero and are not passed on, except for a few length registers when the legacy-mode input is high. Sound writes that are passed on reach the engine through a registered forwarding port of address, data and strobe. The sound master-control byte combines one bit from the bus with the channel-active flags that the engine reports.

The engines themselves (timer, sound synthesis, display, DMA) sit outside this block. Only their register shadows and strobes are here. The block has no state machine: its only sequential behaviour is the edge-triggered storage and the registered side-effect outputs.

Top module: `periph_regbank`

## Requirements
- R1: A read with `rd_i` high at a mapped address returns the stored byte OR a fixed mask. The masks are: 0x02 → 0x7E, 0x07 → 0xF8, 0x0F → 0xE0, 0xFF → 0xE0, 0x41 → 0x80, 0x10 → 0x80, 0x11 → 0x3F, 0x16 → 0x3F, 0x1B → 0xFF, 0x20 → 0xFF and 0x26 → 0x70. Every other mapped address (0x01, 0x05, 0x12, 0x24, 0x25, 0x40, 0x47, 0x48, 0x49) has mask 0x00.
- R2: A read of an unmapped address returns 0xFF, and this includes the divider address 0x04. While `rd_i` is low, `rdata_o` is 0x00.
- R3: A write to the interrupt flag at 0x0F stores the data OR 0xE0.
- R4: A write to 0x04 changes no stored byte. Instead, `div_rst_o` is high for exactly the one cycle after the write edge, whatever the data.
- R5: The sound registers are 0x10, 0x11, 0x12, 0x16, 0x1B, 0x20, 0x24 and 0x25. With `aud_en_i` high, a write to one of them stores the data and forwards it. With `aud_en_i` low and `legacy_i` low, the write stores 0x00 and is not forwarded. A forwarded write appears on `aud_wr_o`/`aud_addr_o`/`aud_data_o` in the cycle after the write edge.
- R6: With `legacy_i` high and `aud_en_i` low, a write to 0x11 or 0x16 stores 0x00 but is still forwarded, with data AND 0x3F.
- R7: With `legacy_i` high, writes to 0x1B and 0x20 are stored and forwarded unchanged even while `aud_en_i` is low.
- R8: A write to 0x26 stores bus bit 7 and, in bits 3:0, the value of `ch_active_i` at that edge. Bits 6:4 are stored as 0. The write is always forwarded.
- R9: After reset the registers read: 0x26 = 0xF1, 0x24 = 0x77, 0x25 = 0xF3, 0x40 = 0x91, 0x47 = 0xFC, 0x48 = 0xFF, 0x49 = 0xFF, 0x0F = 0xE1, 0x11 = 0xBF.
- R10: A write takes effect at the rising clock edge where `wr_i` is high. A read in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| aud_en_i | input | 1 | Sound engine master enable |
| legacy_i | input | 1 | Legacy-mode select |
| ch_active_i | input | 4 | Channel-active flags from the sound engine |
| div_rst_o | output | 1 | One-cycle divider reset pulse |
| aud_wr_o | output | 1 | Forwarded sound write strobe |
| aud_addr_o | output | 8 | Forwarded sound write address |
| aud_data_o | output | 8 | Forwarded sound write data |

## Verification
Storage update and combinational read-back can fall in the same cycle when `rd_i` and `wr_i` are both high at one address. The bench provokes this on the background palette, writing 0x3C while reading it. It expects the reset value 0xFC in that cycle and 0x3C on the following read. The registered side-effect outputs are judged one cycle after each write edge, so a strobe that came too early or was held too long shows up as a mismatch.

// File: rtl/periph_regbank_pkg.sv
package periph_regbank_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NREG  = 20;
    localparam int IDX_W = $clog2(NREG);

    localparam logic [AW-1:0] A_SER_DATA = 8'h01;
    localparam logic [AW-1:0] A_SER_CTRL = 8'h02;
    localparam logic [AW-1:0] A_DIV      = 8'h04;
    localparam logic [AW-1:0] A_TMR_CNT  = 8'h05;
    localparam logic [AW-1:0] A_TMR_CTRL = 8'h07;
    localparam logic [AW-1:0] A_IRQ_FLAG = 8'h0F;
    localparam logic [AW-1:0] A_P1_SWEEP = 8'h10;
    localparam logic [AW-1:0] A_P1_LEN   = 8'h11;
    localparam logic [AW-1:0] A_P1_ENV   = 8'h12;
    localparam logic [AW-1:0] A_P2_LEN   = 8'h16;
    localparam logic [AW-1:0] A_W_LEN    = 8'h1B;
    localparam logic [AW-1:0] A_N_LEN    = 8'h20;
    localparam logic [AW-1:0] A_MIX_VOL  = 8'h24;
    localparam logic [AW-1:0] A_PAN      = 8'h25;
    localparam logic [AW-1:0] A_MASTER   = 8'h26;
    localparam logic [AW-1:0] A_LCD_CTRL = 8'h40;
    localparam logic [AW-1:0] A_LCD_STAT = 8'h41;
    localparam logic [AW-1:0] A_BG_PAL   = 8'h47;
    localparam logic [AW-1:0] A_OBJ_PAL0 = 8'h48;
    localparam logic [AW-1:0] A_OBJ_PAL1 = 8'h49;
    localparam logic [AW-1:0] A_IRQ_EN   = 8'hFF;

    localparam int I_IRQF   = 4;
    localparam int I_MASTER = 13;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_PLAIN,
        CL_IRQF,
        CL_DIV,
        CL_AUD,
        CL_PLEN,
        CL_LLEN,
        CL_MASTER
    } reg_class_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    mask;
        reg_class_e       cls;
    } reg_info_t;

    function automatic reg_info_t mk_info(input int i, input logic [DW-1:0] m,
                                          input reg_class_e c);
        reg_info_t r;
        r.hit  = 1'b1;
        r.idx  = IDX_W'(i);
        r.mask = m;
        r.cls  = c;
        return r;
    endfunction

    function automatic reg_info_t decode_addr(input logic [AW-1:0] a);
        reg_info_t r;
        r.hit  = 1'b0;
        r.idx  = '0;
        r.mask = '1;
        r.cls  = CL_NONE;
        case (a)
            A_SER_DATA: r = mk_info(0,  8'h00, CL_PLAIN);
            A_SER_CTRL: r = mk_info(1,  8'h7E, CL_PLAIN);
            A_TMR_CNT:  r = mk_info(2,  8'h00, CL_PLAIN);
            A_TMR_CTRL: r = mk_info(3,  8'hF8, CL_PLAIN);
            A_IRQ_FLAG: r = mk_info(4,  8'hE0, CL_IRQF);
            A_P1_SWEEP: r = mk_info(5,  8'h80, CL_AUD);
            A_P1_LEN:   r = mk_info(6,  8'h3F, CL_PLEN);
            A_P1_ENV:   r = mk_info(7,  8'h00, CL_AUD);
            A_P2_LEN:   r = mk_info(8,  8'h3F, CL_PLEN);
            A_W_LEN:    r = mk_info(9,  8'hFF, CL_LLEN);
            A_N_LEN:    r = mk_info(10, 8'hFF, CL_LLEN);
            A_MIX_VOL:  r = mk_info(11, 8'h00, CL_AUD);
            A_PAN:      r = mk_info(12, 8'h00, CL_AUD);
            A_MASTER:   r = mk_info(13, 8'h70, CL_MASTER);
            A_LCD_CTRL: r = mk_info(14, 8'h00, CL_PLAIN);
            A_LCD_STAT: r = mk_info(15, 8'h80, CL_PLAIN);
            A_BG_PAL:   r = mk_info(16, 8'h00, CL_PLAIN);
            A_OBJ_PAL0: r = mk_info(17, 8'h00, CL_PLAIN);
            A_OBJ_PAL1: r = mk_info(18, 8'h00, CL_PLAIN);
            A_IRQ_EN:   r = mk_info(19, 8'hE0, CL_PLAIN);
            A_DIV:      r.cls = CL_DIV;
            default:    r.cls = CL_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] reset_value(input logic [IDX_W-1:0] i);
        logic [DW-1:0] v;
        case (i)
            IDX_W'(4):  v = 8'hE1;
            IDX_W'(5):  v = 8'h80;
            IDX_W'(6):  v = 8'hBF;
            IDX_W'(7):  v = 8'hF3;
            IDX_W'(8):  v = 8'h3F;
            IDX_W'(9):  v = 8'hFF;
            IDX_W'(10): v = 8'hFF;
            IDX_W'(11): v = 8'h77;
            IDX_W'(12): v = 8'hF3;
            IDX_W'(13): v = 8'hF1;
            IDX_W'(14): v = 8'h91;
            IDX_W'(16): v = 8'hFC;
            IDX_W'(17): v = 8'hFF;
            IDX_W'(18): v = 8'hFF;
            default:    v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/periph_reg_decode.sv
module periph_reg_decode
    import periph_regbank_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_info_t         info_o
);

    always_comb begin
        info_o = decode_addr(AW'(addr_i));
    end

endmodule

// File: rtl/periph_wr_gate.sv
module periph_wr_gate
    import periph_regbank_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW,
    parameter int CH_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hit_i,
    input  reg_class_e        cls_i,
    input  logic              aud_en_i,
    input  logic              legacy_i,
    input  logic [CH_N-1:0]   ch_active_i,
    output logic              st_en_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              div_rst_o,
    output logic              aud_wr_o,
    output logic [ADDR_W-1:0] aud_addr_o,
    output logic [DATA_W-1:0] aud_data_o
);

    localparam logic [DATA_W-1:0] IRQ_TOP  = DATA_W'(8'hE0);
    localparam logic [DATA_W-1:0] PLEN_KEEP = DATA_W'(8'h3F);
    localparam int GAP_W = DATA_W - 1 - CH_N;

    logic              fwd_c;
    logic [DATA_W-1:0] fwd_data_c;
    logic              div_c;

    always_comb begin
        st_en_o    = 1'b0;
        st_data_o  = wdata_i;
        fwd_c      = 1'b0;
        fwd_data_c = wdata_i;
        div_c      = 1'b0;
        if (wr_i) begin
            unique case (cls_i)
                CL_NONE: ;
                CL_PLAIN: st_en_o = hit_i;
                CL_IRQF: begin
                    st_en_o   = hit_i;
                    st_data_o = wdata_i | IRQ_TOP;
                end
                CL_DIV: div_c = 1'b1;
                CL_AUD: begin
                    st_en_o = hit_i;
                    if (aud_en_i) begin
                        fwd_c = 1'b1;
                    end else begin
                        st_data_o = '0;
                    end
                end
                CL_PLEN: begin
                    st_en_o = hit_i;
                    if (aud_en_i) begin
                        fwd_c = 1'b1;
                    end else begin
                        st_data_o  = '0;
                        fwd_c      = legacy_i;
                        fwd_data_c = wdata_i & PLEN_KEEP;
                    end
                end
                CL_LLEN: begin
                    st_en_o = hit_i;
                    if (aud_en_i || legacy_i) begin
                        fwd_c = 1'b1;
                    end else begin
                        st_data_o = '0;
                    end
                end
                CL_MASTER: begin
                    st_en_o   = hit_i;
                    st_data_o = {wdata_i[DATA_W-1], {GAP_W{1'b0}}, ch_active_i};
                    fwd_c     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_rst_o  <= 1'b0;
            aud_wr_o   <= 1'b0;
            aud_addr_o <= '0;
            aud_data_o <= '0;
        end else begin
            div_rst_o <= div_c;
            aud_wr_o  <= fwd_c;
            if (fwd_c) begin
                aud_addr_o <= addr_i;
                aud_data_o <= fwd_data_c;
            end
        end
    end

    assert_div_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_o |-> $past(wr_i && cls_i == CL_DIV));

    assert_aud_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !aud_en_i && !legacy_i && (cls_i inside {CL_AUD, CL_PLEN, CL_LLEN}))
        |=> !aud_wr_o);

    assert_plen_trim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !aud_en_i && legacy_i && cls_i == CL_PLEN)
        |=> (aud_wr_o && aud_data_o[DATA_W-1:DATA_W-2] == 2'b00));

endmodule

// File: rtl/periph_reg_cells.sv
module periph_reg_cells
    import periph_regbank_pkg::*;
#(
    parameter int N_REG  = NREG,
    parameter int DATA_W = DW,
    parameter int IW     = IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [IW-1:0]                widx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [N_REG-1:0][DATA_W-1:0] q_o
);

    for (genvar g = 0; g < N_REG; g++) begin : g_cell
        logic [DATA_W-1:0] cell_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_r <= DATA_W'(reset_value(IDX_W'(g)));
            end else if (we_i && widx_i == IW'(g)) begin
                cell_r <= wdata_i;
            end
        end
        assign q_o[g] = cell_r;
    end

    assert_irqf_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_o[I_IRQF][7:5] == 3'b111);

endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
    import periph_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output logic [DW-1:0] rdata_o,
    input  logic          aud_en_i,
    input  logic          legacy_i,
    input  logic [3:0]    ch_active_i,
    output logic          div_rst_o,
    output logic          aud_wr_o,
    output logic [AW-1:0] aud_addr_o,
    output logic [DW-1:0] aud_data_o
);

    reg_info_t                 info;
    logic                      st_en;
    logic [DW-1:0]             st_data;
    logic [NREG-1:0][DW-1:0]   cell_q;

    periph_reg_decode #(.ADDR_W(AW)) u_decode (
        .addr_i (addr_i),
        .info_o (info)
    );

    periph_wr_gate #(.DATA_W(DW), .ADDR_W(AW), .CH_N(4)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .hit_i       (info.hit),
        .cls_i       (info.cls),
        .aud_en_i    (aud_en_i),
        .legacy_i    (legacy_i),
        .ch_active_i (ch_active_i),
        .st_en_o     (st_en),
        .st_data_o   (st_data),
        .div_rst_o   (div_rst_o),
        .aud_wr_o    (aud_wr_o),
        .aud_addr_o  (aud_addr_o),
        .aud_data_o  (aud_data_o)
    );

    periph_reg_cells #(.N_REG(NREG), .DATA_W(DW), .IW(IDX_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_en),
        .widx_i  (info.idx),
        .wdata_i (st_data),
        .q_o     (cell_q)
    );

    always_comb begin
        if (!rd_i) begin
            rdata_o = '0;
        end else if (info.hit) begin
            rdata_o = cell_q[info.idx] | info.mask;
        end else begin
            rdata_o = '1;
        end
    end

    assert_master_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MASTER) |=> (cell_q[I_MASTER][6:4] == 3'b000));

    assert_master_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MASTER) |=> (aud_wr_o && aud_addr_o == A_MASTER));

endmodule

// File: tb/periph_regbank_bench.sv
module periph_regbank_bench;

    localparam int K_RD  = 0;
    localparam int K_DIV = 1;
    localparam int K_AWR = 2;

    typedef struct {
        int          kind;
        logic [16:0] val;
        string       tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       aud_en = 1'b1;
    logic       legacy = 1'b0;
    logic [3:0] ch_act = 4'h0;
    logic       div_rst;
    logic       aud_wr;
    logic [7:0] aud_addr;
    logic [7:0] aud_data;

    int vectors = 0;
    int errors  = 0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    periph_regbank u_periph_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .wr_i        (wr),
        .rd_i        (rd),
        .rdata_o     (rdata),
        .aud_en_i    (aud_en),
        .legacy_i    (legacy),
        .ch_active_i (ch_act),
        .div_rst_o   (div_rst),
        .aud_wr_o    (aud_wr),
        .aud_addr_o  (aud_addr),
        .aud_data_o  (aud_data)
    );

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin : monitor
        item_t it;
        while (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            vectors++;
            if (it.kind == K_RD) begin
                if (rdata !== it.val[7:0]) begin
                    errors++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.val[7:0]);
                end
            end else if (it.kind == K_DIV) begin
                if (div_rst !== it.val[0]) begin
                    errors++;
                    $display("FAIL %s: div_rst actual %b expected %b", it.tag, div_rst, it.val[0]);
                end
            end else begin
                if (it.val[16] == 1'b0) begin
                    if (aud_wr !== 1'b0) begin
                        errors++;
                        $display("FAIL %s: aud_wr actual %b expected 0", it.tag, aud_wr);
                    end
                end else if ({aud_wr, aud_addr, aud_data} !== it.val) begin
                    errors++;
                    $display("FAIL %s: forward actual %b/%h/%h expected %b/%h/%h", it.tag,
                             aud_wr, aud_addr, aud_data, it.val[16], it.val[15:8], it.val[7:0]);
                end
            end
        end
    end

    task automatic rd_chk(input logic [7:0] a, input logic lvl, input logic [7:0] e,
                          input string tag);
        @(posedge clk); #1;
        addr = a; rd = lvl; wr = 1'b0;
        exp_q.push_back('{K_RD, {9'h0, e}, tag});
        @(negedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic wr_chk(input logic [7:0] a, input logic [7:0] d, input logic e_div,
                          input logic e_fwd, input logic [7:0] e_data, input string tag);
        @(posedge clk); #1;
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
        @(posedge clk); #1;
        wr = 1'b0;
        exp_q.push_back('{K_DIV, {16'h0, e_div}, tag});
        exp_q.push_back('{K_AWR, {e_fwd, a, e_data}, tag});
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset values
        rd_chk(8'h26, 1, 8'hF1, "R9 master");
        rd_chk(8'h24, 1, 8'h77, "R9 volume");
        rd_chk(8'h25, 1, 8'hF3, "R9 pan");
        rd_chk(8'h40, 1, 8'h91, "R9 lcd ctrl");
        rd_chk(8'h47, 1, 8'hFC, "R9 bg pal");
        rd_chk(8'h48, 1, 8'hFF, "R9 obj pal0");
        rd_chk(8'h49, 1, 8'hFF, "R9 obj pal1");
        rd_chk(8'h0F, 1, 8'hE1, "R9 irq flag");
        rd_chk(8'h11, 1, 8'hBF, "R9 pulse1 len");

        // R2 unmapped and idle read
        rd_chk(8'h03, 1, 8'hFF, "R2 unmapped 03");
        rd_chk(8'h80, 1, 8'hFF, "R2 unmapped 80");
        rd_chk(8'h04, 1, 8'hFF, "R2 divider reads FF");
        rd_chk(8'h40, 0, 8'h00, "R2 idle read");

        // R1 masked bits read as 1 after writing zero
        wr_chk(8'h02, 8'h00, 0, 0, 8'h00, "R1 ser ctrl wr");
        rd_chk(8'h02, 1, 8'h7E, "R1 ser ctrl mask");
        wr_chk(8'h07, 8'h00, 0, 0, 8'h00, "R1 tmr ctrl wr");
        rd_chk(8'h07, 1, 8'hF8, "R1 tmr ctrl mask");
        wr_chk(8'hFF, 8'h00, 0, 0, 8'h00, "R1 irq en wr");
        rd_chk(8'hFF, 1, 8'hE0, "R1 irq en mask");
        wr_chk(8'h41, 8'h00, 0, 0, 8'h00, "R1 lcd stat wr");
        rd_chk(8'h41, 1, 8'h80, "R1 lcd stat mask");
        wr_chk(8'h10, 8'h00, 0, 1, 8'h00, "R1 sweep wr");
        rd_chk(8'h10, 1, 8'h80, "R1 sweep mask");
        wr_chk(8'h11, 8'h00, 0, 1, 8'h00, "R1 p1 len wr");
        rd_chk(8'h11, 1, 8'h3F, "R1 p1 len mask");
        wr_chk(8'h16, 8'h00, 0, 1, 8'h00, "R1 p2 len wr");
        rd_chk(8'h16, 1, 8'h3F, "R1 p2 len mask");
        wr_chk(8'h1B, 8'h00, 0, 1, 8'h00, "R1 wave len wr");
        rd_chk(8'h1B, 1, 8'hFF, "R1 wave len mask");
        wr_chk(8'h20, 8'h00, 0, 1, 8'h00, "R1 noise len wr");
        rd_chk(8'h20, 1, 8'hFF, "R1 noise len mask");
        wr_chk(8'h01, 8'hA5, 0, 0, 8'h00, "R1 ser data wr");
        rd_chk(8'h01, 1, 8'hA5, "R1 ser data no mask");

        // R3 interrupt flag
        wr_chk(8'h0F, 8'h00, 0, 0, 8'h00, "R3 irq flag zero");
        rd_chk(8'h0F, 1, 8'hE0, "R3 irq flag zero rd");
        wr_chk(8'h0F, 8'h05, 0, 0, 8'h00, "R3 irq flag 05");
        rd_chk(8'h0F, 1, 8'hE5, "R3 irq flag 05 rd");

        // R4 divider pulse
        wr_chk(8'h04, 8'h5A, 1, 0, 8'h00, "R4 div pulse");
        rd_chk(8'h04, 1, 8'hFF, "R4 div not stored");
        exp_q.push_back('{K_DIV, 17'h0, "R4 div pulse ends"});
        @(negedge clk);
        wr_chk(8'h04, 8'h00, 1, 0, 8'h00, "R4 div pulse any data");

        // R5 sound power gating
        aud_en = 1'b0; legacy = 1'b0;
        wr_chk(8'h12, 8'h77, 0, 0, 8'h00, "R5 off env wr");
        rd_chk(8'h12, 1, 8'h00, "R5 off env stored zero");
        wr_chk(8'h11, 8'hC5, 0, 0, 8'h00, "R5 off p1 len wr");
        rd_chk(8'h11, 1, 8'h3F, "R5 off p1 len stored zero");
        wr_chk(8'h24, 8'h55, 0, 0, 8'h00, "R5 off volume wr");
        rd_chk(8'h24, 1, 8'h00, "R5 off volume stored zero");
        wr_chk(8'h20, 8'h9C, 0, 0, 8'h00, "R5 off noise len not fwd");
        aud_en = 1'b1;
        wr_chk(8'h24, 8'h55, 0, 1, 8'h55, "R5 on volume fwd");
        rd_chk(8'h24, 1, 8'h55, "R5 on volume stored");

        // R6 legacy pulse length
        aud_en = 1'b0; legacy = 1'b1;
        wr_chk(8'h16, 8'hC7, 0, 1, 8'h07, "R6 p2 len fwd trimmed");
        rd_chk(8'h16, 1, 8'h3F, "R6 p2 len stored zero");
        wr_chk(8'h11, 8'hFF, 0, 1, 8'h3F, "R6 p1 len fwd trimmed");
        wr_chk(8'h12, 8'h33, 0, 0, 8'h00, "R6 legacy env blocked");
        rd_chk(8'h12, 1, 8'h00, "R6 legacy env zero");

        // R7 legacy wave/noise length
        wr_chk(8'h20, 8'h9C, 0, 1, 8'h9C, "R7 noise len fwd");
        wr_chk(8'h1B, 8'h11, 0, 1, 8'h11, "R7 wave len fwd");
        aud_en = 1'b1; legacy = 1'b0;

        // R8 master control
        ch_act = 4'b1010;
        wr_chk(8'h26, 8'h0F, 0, 1, 8'h0F, "R8 master fwd");
        rd_chk(8'h26, 1, 8'h7A, "R8 master low nibble");
        ch_act = 4'b0101;
        wr_chk(8'h26, 8'h80, 0, 1, 8'h80, "R8 master bit7");
        rd_chk(8'h26, 1, 8'hF5, "R8 master rd");

        // R10 read during write
        @(posedge clk); #1;
        addr = 8'h47; wdata = 8'h3C; wr = 1'b1; rd = 1'b1;
        exp_q.push_back('{K_RD, {9'h0, 8'hFC}, "R10 read during write old"});
        @(posedge clk); #1;
        wr = 1'b0; rd = 1'b0;
        rd_chk(8'h47, 1, 8'h3C, "R10 read after write new");

        repeat (2) @(posedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule